// File: doc/BRIEF.md
# Frame-Synchronized I2C Control Register Writer

This block is the write side of a two-wire serial control port that loads a bank of 8-bit adjustment registers. A host sends a START, the device byte, one subaddress byte and one or more data bytes, then a STOP. The slave pulls the data line low to acknowledge each byte it accepts. The bus lines and the blanking input are oversampled on a fast system clock through two-flop synchronizers. START and STOP are recognized as data-line edges while the clock line is high.

The top bit of the subaddress selects when the write lands. With the top bit clear, the transfer is immediate: the register write is issued once the transfer ends. With the top bit set, the transfer is deferred: the byte waits in a holding buffer and is written on the first rising edge of the vertical blanking input that follows the transfer's end. This keeps visible geometry changes inside the flyback period.

While a deferred byte is waiting, the slave refuses the device byte of any further transfer. Deferred transfers are refused in standby. Nothing is acknowledged while the supply-good input is low. The registers themselves sit outside this block. It only drives a one-cycle write strobe carrying a 7-bit register index and a data byte.

Top module: `blank_sync_regslave`

## Requirements
- R1: Only the device byte 8'h8C (1000 1100) is acknowledged. Any other device byte gets no acknowledge and causes no register write.
- R2: When subaddress bit 7 is 0, no write happens before the transfer ends. After STOP, exactly one write strobe is issued, with index = subaddress[6:0] and the received data.
- R3: When a transfer carries several data bytes, the index does not advance. A single write to subaddress[6:0] is issued, carrying the last data byte.
- R4: When subaddress bit 7 is 1, no write is issued at STOP. Exactly one write of the held index and byte is issued after the first rising edge of the blanking input that follows the STOP.
- R5: After an accepted deferred transfer, the device byte is not acknowledged until a blanking rising edge has committed the held byte. Afterwards it is acknowledged again.
- R6: While the standby input is high, a subaddress with bit 7 set is not acknowledged and no write results. Immediate transfers still work.
- R7: While the supply-good input is low, no byte is acknowledged and no write occurs.
- R8: A STOP that arrives after the subaddress but before any data byte ends the transfer with no write. A deferred transfer cut short this way neither fills the holding buffer nor locks the port.
- R9: A repeated START ends the running transfer in the same way as a STOP. An immediate write is issued and the new transfer proceeds.
- R10: A blanking edge with no held byte produces no write. Any number of immediate transfers may be made between blanking edges, each giving its own write.
- R11: During and right after reset, the write strobe is low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the wire (asynchronous) |
| sda_oe_o | output | 1 | High pulls the data line low (open-drain acknowledge) |
| blank_i | input | 1 | Vertical blanking pulse, commits on its rising edge |
| standby_i | input | 1 | High disables deferred transfers |
| supply_ok_i | input | 1 | Low suppresses every acknowledge |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_idx_o | output | 7 | Register index for the write |
| wr_data_o | output | 8 | Data for the write |

## Verification
Immediate transfers are exercised with one and with three data bytes and with random indices and values. This shows whether the write lands once, on the right register, with the last byte, and only after the transfer closes. Deferred transfers are checked at three points: after STOP, after a second attempt during lockout, and after the blanking edge. This separates commit-on-blank from commit-on-stop and shows when the lock is released. Early STOP, repeated START, standby, low supply and foreign device bytes each show whether an abort or refusal leaves both the write port and the lock untouched.

// File: rtl/bss_pkg.sv
package bss_pkg;
    localparam int IDX_W  = 7;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] DEV_BYTE = 8'h8C;

    typedef enum logic [1:0] {LK_IDLE, LK_RX, LK_ACK, LK_SKIP} lk_state_e;
    typedef enum logic [1:0] {PH_DEV, PH_SUB, PH_DAT} lk_phase_e;
endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < DEPTH; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/bss_link.sv
module bss_link
    import bss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s_i,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_rise_i,
    input  logic              sda_fall_i,
    input  logic              supply_ok_i,
    input  logic              standby_i,
    input  logic              lock_i,
    output logic              sda_oe_o,
    output logic              addr_ack_o,
    output logic              ev_sub_o,
    output logic              ev_data_o,
    output logic              ev_end_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        lk_state_e         state;
        lk_phase_e         phase;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sr;
        logic              oe;
        logic              addr_ack;
        logic              ev_sub;
        logic              ev_data;
        logic              ev_end;
    } link_t;

    link_t lk_d, lk_q;
    logic  start_c, stop_c, ok_c;

    always_comb begin
        lk_d          = lk_q;
        lk_d.addr_ack = 1'b0;
        lk_d.ev_sub   = 1'b0;
        lk_d.ev_data  = 1'b0;
        lk_d.ev_end   = 1'b0;
        start_c       = scl_s_i & sda_fall_i;
        stop_c        = scl_s_i & sda_rise_i;
        ok_c          = 1'b0;

        if (start_c) begin
            // a START inside a transfer closes it like a STOP
            lk_d.ev_end = (lk_q.state != LK_IDLE);
            lk_d.state  = LK_RX;
            lk_d.phase  = PH_DEV;
            lk_d.cnt    = '0;
            lk_d.oe     = 1'b0;
        end else if (stop_c) begin
            lk_d.ev_end = (lk_q.state != LK_IDLE);
            lk_d.state  = LK_IDLE;
            lk_d.oe     = 1'b0;
        end else begin
            unique case (lk_q.state)
                LK_RX: begin
                    if (scl_rise_i && lk_q.cnt != FULL) begin
                        lk_d.sr  = {lk_q.sr[BYTE_W-2:0], sda_s_i};
                        lk_d.cnt = lk_q.cnt + 1'b1;
                    end else if (scl_fall_i && lk_q.cnt == FULL) begin
                        unique case (lk_q.phase)
                            PH_DEV: begin
                                ok_c = supply_ok_i && !lock_i && (lk_q.sr == DEV_BYTE);
                                lk_d.addr_ack = ok_c;
                            end
                            PH_SUB: begin
                                ok_c = supply_ok_i && !(lk_q.sr[BYTE_W-1] && standby_i);
                                lk_d.ev_sub = ok_c;
                            end
                            default: begin
                                ok_c = supply_ok_i;
                                lk_d.ev_data = ok_c;
                            end
                        endcase
                        lk_d.oe    = ok_c;
                        lk_d.state = ok_c ? LK_ACK : LK_SKIP;
                    end
                end
                LK_ACK: begin
                    if (scl_fall_i) begin
                        lk_d.oe    = 1'b0;
                        lk_d.cnt   = '0;
                        lk_d.state = LK_RX;
                        lk_d.phase = (lk_q.phase == PH_DEV) ? PH_SUB : PH_DAT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '{state: LK_IDLE, phase: PH_DEV, default: '0};
        end else begin
            lk_q <= lk_d;
        end
    end

    assign sda_oe_o   = lk_q.oe;
    assign addr_ack_o = lk_q.addr_ack;
    assign ev_sub_o   = lk_q.ev_sub;
    assign ev_data_o  = lk_q.ev_data;
    assign ev_end_o   = lk_q.ev_end;
    assign byte_o     = lk_q.sr;
endmodule

// File: rtl/bss_commit.sv
module bss_commit
    import bss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_sub_i,
    input  logic              ev_data_i,
    input  logic              ev_end_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              blank_rise_i,
    output logic              lock_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    typedef struct packed {
        logic              sub_ok;
        logic              deferred;
        logic [IDX_W-1:0]  idx;
        logic              have_data;
        logic [BYTE_W-1:0] stage;
        logic              pending;
        logic [IDX_W-1:0]  hold_idx;
        logic [BYTE_W-1:0] hold_data;
        logic              wr_en;
        logic [IDX_W-1:0]  wr_idx;
        logic [BYTE_W-1:0] wr_data;
    } cm_t;

    cm_t cm_d, cm_q;

    always_comb begin
        cm_d       = cm_q;
        cm_d.wr_en = 1'b0;

        if (blank_rise_i && cm_q.pending) begin
            cm_d.pending = 1'b0;
            cm_d.wr_en   = 1'b1;
            cm_d.wr_idx  = cm_q.hold_idx;
            cm_d.wr_data = cm_q.hold_data;
        end

        if (ev_sub_i) begin
            cm_d.sub_ok    = 1'b1;
            cm_d.deferred  = byte_i[BYTE_W-1];
            cm_d.idx       = byte_i[IDX_W-1:0];
            cm_d.have_data = 1'b0;
        end

        // no auto-increment: every data byte replaces the staged one
        if (ev_data_i && cm_q.sub_ok) begin
            cm_d.stage     = byte_i;
            cm_d.have_data = 1'b1;
        end

        if (ev_end_i) begin
            if (cm_q.sub_ok && cm_q.have_data) begin
                if (cm_q.deferred) begin
                    cm_d.pending   = 1'b1;
                    cm_d.hold_idx  = cm_q.idx;
                    cm_d.hold_data = cm_q.stage;
                end else begin
                    cm_d.wr_en   = 1'b1;
                    cm_d.wr_idx  = cm_q.idx;
                    cm_d.wr_data = cm_q.stage;
                end
            end
            cm_d.sub_ok    = 1'b0;
            cm_d.have_data = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_q <= '0;
        end else begin
            cm_q <= cm_d;
        end
    end

    assign lock_o    = cm_q.pending;
    assign wr_en_o   = cm_q.wr_en;
    assign wr_idx_o  = cm_q.wr_idx;
    assign wr_data_o = cm_q.wr_data;
endmodule

// File: rtl/blank_sync_regslave.sv
module blank_sync_regslave
    import bss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              blank_i,
    input  logic              standby_i,
    input  logic              supply_ok_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam int NSYNC = 3;
    localparam int B_SCL = 0;
    localparam int B_SDA = 1;
    localparam int B_BLK = 2;

    logic [NSYNC-1:0]  sync_w, prev_w;
    logic              scl_rise_w, scl_fall_w, sda_rise_w, sda_fall_w, blank_rise_w;
    logic              lock_w, addr_ack_w, ev_sub_w, ev_data_w, ev_end_w;
    logic [BYTE_W-1:0] byte_w;

    bss_sync #(
        .WIDTH   (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b011)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({blank_i, sda_i, scl_i}),
        .sync_o  (sync_w),
        .prev_o  (prev_w)
    );

    assign scl_rise_w   =  sync_w[B_SCL] & ~prev_w[B_SCL];
    assign scl_fall_w   = ~sync_w[B_SCL] &  prev_w[B_SCL];
    assign sda_rise_w   =  sync_w[B_SDA] & ~prev_w[B_SDA];
    assign sda_fall_w   = ~sync_w[B_SDA] &  prev_w[B_SDA];
    assign blank_rise_w =  sync_w[B_BLK] & ~prev_w[B_BLK];

    bss_link u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s_i     (sync_w[B_SCL]),
        .sda_s_i     (sync_w[B_SDA]),
        .scl_rise_i  (scl_rise_w),
        .scl_fall_i  (scl_fall_w),
        .sda_rise_i  (sda_rise_w),
        .sda_fall_i  (sda_fall_w),
        .supply_ok_i (supply_ok_i),
        .standby_i   (standby_i),
        .lock_i      (lock_w),
        .sda_oe_o    (sda_oe_o),
        .addr_ack_o  (addr_ack_w),
        .ev_sub_o    (ev_sub_w),
        .ev_data_o   (ev_data_w),
        .ev_end_o    (ev_end_w),
        .byte_o      (byte_w)
    );

    bss_commit u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_sub_i     (ev_sub_w),
        .ev_data_i    (ev_data_w),
        .ev_end_i     (ev_end_w),
        .byte_i       (byte_w),
        .blank_rise_i (blank_rise_w),
        .lock_o       (lock_w),
        .wr_en_o      (wr_en_o),
        .wr_idx_o     (wr_idx_o),
        .wr_data_o    (wr_data_o)
    );
endmodule

// File: rtl/bss_chk.sv
module bss_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok_i,
    input logic       standby_i,
    input logic       sda_oe_o,
    input logic       wr_en_o,
    input logic       lock_w,
    input logic       addr_ack_w,
    input logic       ev_sub_w,
    input logic       ev_end_w,
    input logic       blank_rise_w,
    input logic [7:0] byte_w
);
    // R7
    supply_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> !$rose(sda_oe_o));

    // R5
    lock_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_w |-> !lock_w);

    // R6
    standby_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sub_w |-> !(byte_w[7] && $past(standby_i)));

    // R2
    write_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(ev_end_w || blank_rise_w));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R4
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_w && blank_rise_w) |=> (wr_en_o && !lock_w));
endmodule

bind blank_sync_regslave bss_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok_i  (supply_ok_i),
    .standby_i    (standby_i),
    .sda_oe_o     (sda_oe_o),
    .wr_en_o      (wr_en_o),
    .lock_w       (lock_w),
    .addr_ack_w   (addr_ack_w),
    .ev_sub_w     (ev_sub_w),
    .ev_end_w     (ev_end_w),
    .blank_rise_w (blank_rise_w),
    .byte_w       (byte_w)
);

// File: tb/test_blank_sync_regslave.sv
module test_blank_sync_regslave;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       blank = 1'b0;
    logic       standby = 1'b0;
    logic       supply_ok = 1'b1;
    logic       sda_oe;
    logic       wr_en;
    logic [6:0] wr_idx;
    logic [7:0] wr_data;
    logic       sda_line;

    int         n_checks = 0;
    int         n_errors = 0;
    int         wr_count = 0;
    logic [6:0] last_idx = '0;
    logic [7:0] last_data = '0;
    bit         done = 1'b0;

    assign sda_line = sda_drv & ~sda_oe;

    always #10 clk = ~clk;

    blank_sync_regslave i_blank_sync_regslave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_drv),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .blank_i     (blank),
        .standby_i   (standby),
        .supply_ok_i (supply_ok),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data)
    );

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            wr_count  <= wr_count + 1;
            last_idx  <= wr_idx;
            last_data <= wr_data;
        end
    end

    function automatic logic [6:0] exp_idx(input logic [7:0] sub);
        return sub[6:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q); scl_drv = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q); scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; tick(Q); scl_drv = 1'b1; tick(2*Q);
            scl_drv = 1'b0; tick(Q);
        end
        sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
        @(negedge clk); ack = ~sda_line;
        tick(Q); scl_drv = 1'b0; tick(Q);
    endtask

    // ackv bit0 = device byte, bit1 = subaddress, bit2.. = data bytes
    task automatic xfer(input logic [7:0] dev, input logic [7:0] sub, input int nd,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                        input bit skip_start, input bit no_stop, output logic [4:0] ackv);
        bit a;
        logic [7:0] dat [3];
        dat[0] = d0; dat[1] = d1; dat[2] = d2;
        ackv = '0;
        if (!skip_start) bus_start();
        send_byte(dev, a); ackv[0] = a;
        if (a) begin
            send_byte(sub, a); ackv[1] = a;
            for (int k = 0; k < nd && a; k++) begin
                send_byte(dat[k], a); ackv[2+k] = a;
            end
        end
        if (!no_stop) begin bus_stop(); tick(12); end
    endtask

    task automatic rstart();
        sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q); scl_drv = 1'b0; tick(Q);
    endtask

    task automatic blank_pulse();
        blank = 1'b1; tick(4); blank = 1'b0; tick(8);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] av;
        int c0;
        int seed;
        seed = $urandom(32'h1d3c5);

        tick(3);
        @(negedge clk);
        // R11 reset state
        chk(wr_en == 1'b0, "R11", "wr_en in reset", int'(wr_en), 0);
        chk(sda_oe == 1'b0, "R11", "sda_oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1; tick(5);
        @(negedge clk);
        chk(wr_en == 1'b0 && sda_oe == 1'b0, "R11", "idle after reset",
            int'({wr_en, sda_oe}), 0);

        // R1 foreign device byte
        c0 = wr_count;
        xfer(8'h8E, 8'h05, 1, 8'hAA, 8'h0, 8'h0, 0, 0, av);
        chk(av[0] == 1'b0, "R1", "foreign device ack", int'(av[0]), 0);
        chk(wr_count == c0, "R1", "foreign device writes", wr_count - c0, 0);

        // R2 direct single byte, nothing before STOP
        c0 = wr_count;
        xfer(8'h8C, 8'h12, 1, 8'h5A, 8'h0, 8'h0, 0, 1, av);
        chk(av[2:0] == 3'b111, "R1", "direct acks", int'(av[2:0]), 7);
        tick(20);
        chk(wr_count == c0, "R2", "write before STOP", wr_count - c0, 0);
        bus_stop(); tick(12);
        chk(wr_count == c0 + 1, "R2", "write count", wr_count - c0, 1);
        chk(last_idx == exp_idx(8'h12) && last_data == 8'h5A, "R2", "write value",
            int'({last_idx, last_data}), int'({exp_idx(8'h12), 8'h5A}));

        // R3 three bytes, no auto-increment
        c0 = wr_count;
        xfer(8'h8C, 8'h33, 3, 8'h11, 8'h22, 8'h3C, 0, 0, av);
        chk(wr_count == c0 + 1, "R3", "multi-byte write count", wr_count - c0, 1);
        chk(last_idx == 7'h33 && last_data == 8'h3C, "R3", "multi-byte value",
            int'({last_idx, last_data}), int'({7'h33, 8'h3C}));

        // R4 deferred write commits on blank
        c0 = wr_count;
        xfer(8'h8C, 8'hC4, 1, 8'h99, 8'h0, 8'h0, 0, 0, av);
        chk(av[2:0] == 3'b111, "R4", "deferred acks", int'(av[2:0]), 7);
        chk(wr_count == c0, "R4", "no write at STOP", wr_count - c0, 0);

        // R5 lockout until blank
        xfer(8'h8C, 8'h01, 1, 8'h77, 8'h0, 8'h0, 0, 0, av);
        chk(av[0] == 1'b0, "R5", "device ack while locked", int'(av[0]), 0);
        chk(wr_count == c0, "R5", "no write while locked", wr_count - c0, 0);
        blank_pulse();
        chk(wr_count == c0 + 1, "R4", "commit on blank", wr_count - c0, 1);
        chk(last_idx == 7'h44 && last_data == 8'h99, "R4", "commit value",
            int'({last_idx, last_data}), int'({7'h44, 8'h99}));
        c0 = wr_count;
        xfer(8'h8C, 8'h02, 1, 8'h66, 8'h0, 8'h0, 0, 0, av);
        chk(av[0] == 1'b1, "R5", "device ack after blank", int'(av[0]), 1);

        // R10 blank without pending, unlimited direct writes
        blank_pulse();
        chk(wr_count == c0 + 1, "R10", "idle blank writes", wr_count - c0, 1);
        c0 = wr_count;
        for (int k = 0; k < 3; k++) begin
            xfer(8'h8C, 8'(k + 8), 1, 8'(8'h40 + k), 8'h0, 8'h0, 0, 0, av);
        end
        chk(wr_count == c0 + 3, "R10", "back-to-back direct", wr_count - c0, 3);

        // R6 standby refuses deferred, direct still works
        standby = 1'b1;
        c0 = wr_count;
        xfer(8'h8C, 8'h85, 1, 8'hEE, 8'h0, 8'h0, 0, 0, av);
        chk(av[1:0] == 2'b01, "R6", "deferred sub in standby", int'(av[1:0]), 1);
        blank_pulse();
        chk(wr_count == c0, "R6", "standby deferred writes", wr_count - c0, 0);
        xfer(8'h8C, 8'h06, 1, 8'hEF, 8'h0, 8'h0, 0, 0, av);
        chk(wr_count == c0 + 1 && last_data == 8'hEF, "R6", "direct in standby",
            wr_count - c0, 1);
        standby = 1'b0;

        // R7 supply low
        supply_ok = 1'b0;
        c0 = wr_count;
        xfer(8'h8C, 8'h07, 1, 8'h12, 8'h0, 8'h0, 0, 0, av);
        chk(av[0] == 1'b0, "R7", "ack with supply low", int'(av[0]), 0);
        chk(wr_count == c0, "R7", "write with supply low", wr_count - c0, 0);
        supply_ok = 1'b1;

        // R8 STOP before data
        c0 = wr_count;
        xfer(8'h8C, 8'hA0, 0, 8'h0, 8'h0, 8'h0, 0, 0, av);
        blank_pulse();
        chk(wr_count == c0, "R8", "early stop writes", wr_count - c0, 0);
        xfer(8'h8C, 8'h09, 1, 8'h5F, 8'h0, 8'h0, 0, 0, av);
        chk(av[0] == 1'b1, "R8", "no lock after early stop", int'(av[0]), 1);

        // R9 repeated START closes the transfer
        c0 = wr_count;
        xfer(8'h8C, 8'h2A, 1, 8'hB1, 8'h0, 8'h0, 0, 1, av);
        rstart(); tick(12);
        chk(wr_count == c0 + 1 && last_idx == 7'h2A && last_data == 8'hB1, "R9",
            "write at repeated start", wr_count - c0, 1);
        xfer(8'h8C, 8'h2B, 1, 8'hB2, 8'h0, 8'h0, 1, 0, av);
        chk(wr_count == c0 + 2 && last_data == 8'hB2, "R9", "transfer after restart",
            wr_count - c0, 2);

        // R2 R3 random direct traffic
        for (int k = 0; k < 16; k++) begin
            logic [7:0] sub, b0, b1, b2, lastb;
            int nd;
            sub = {1'b0, 7'($urandom)};
            b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
            nd = 1 + int'($urandom % 3);
            lastb = (nd == 1) ? b0 : (nd == 2) ? b1 : b2;
            c0 = wr_count;
            xfer(8'h8C, sub, nd, b0, b1, b2, 0, 0, av);
            chk(wr_count == c0 + 1 && last_idx == exp_idx(sub) && last_data == lastb,
                "R3", "random direct", int'({last_idx, last_data}),
                int'({exp_idx(sub), lastb}));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule